// File: doc/BRIEF.md
# Cycle-Skipping Switch Gate Controller

The block decides, once per switching cycle, whether the power switch fires, and it ends each pulse it starts. There is no pulse-width loop. A free-running cycle-start pulse opens each switching period. At that instant the block samples the feedback enable level, the restart permit and the two fault latches. If all of them allow it, the gate turns on for that period. Otherwise the period is skipped and counted. A started pulse ends at whichever comes first: the current-limit flag after a blanking interval, a fresh supply or thermal fault flag, or the end of the duty window.

Comparators, the enable current hysteresis, the oscillator and the auto-restart timer all sit outside this block. They reach it as single-bit levels that are synchronous to the system clock. Supply and thermal protection each arrive as a pair of flags: one flag trips the fault and a separate flag releases it. This lets the outside hysteresis band map onto a set/clear latch held inside the block.

Top module: `onoff_switch_ctrl`

## Requirements
- R1: On a clock edge with `cyc_start_i` high, the gate turns on in the next cycle if `en_i`, `permit_i` and `dmax_i` are high and no fault is latched or arriving. Otherwise the gate stays off for that switching cycle.
- R2: Changes on `en_i` (and `permit_i`) after the cycle-start sample have no effect on the running switching cycle.
- R3: Once blanking has elapsed, a high `ilim_i` turns the gate off at the next clock edge. The gate stays off for the rest of the switching cycle.
- R4: `ilim_i` is ignored on the first `BLANK_CYC` edges after turn-on. With `ilim_i` held high, the gate stays on for exactly `BLANK_CYC`+1 clocks.
- R5: The gate is off in any clock that follows a clock with `dmax_i` low. A pulse never outlasts the duty window.
- R6: `bp_low_i` latches a supply fault and drops the gate at the next edge. The fault is latched at reset. Switching stays disabled until a `bp_ok_i` pulse clears it.
- R7: `hot_i` latches a thermal fault and drops the gate at the next edge. Switching stays disabled until a `cool_i` pulse clears it.
- R8: A cycle start with `permit_i` low is skipped.
- R9: `skip_cnt_o` increments by one for every cycle start that does not fire. It wraps modulo 2^`SKIP_W`.
- R10: After reset `gate_o` is low and `skip_cnt_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_start_i | input | 1 | One-clock pulse that opens a switching cycle |
| dmax_i | input | 1 | Duty window, high while on-time is allowed |
| en_i | input | 1 | Feedback enable level |
| ilim_i | input | 1 | Current-limit comparator flag |
| permit_i | input | 1 | Auto-restart permit |
| bp_low_i | input | 1 | Supply under-voltage trip flag |
| bp_ok_i | input | 1 | Supply recovered flag |
| hot_i | input | 1 | Over-temperature trip flag |
| cool_i | input | 1 | Temperature recovered flag |
| gate_o | output | 1 | Power switch gate drive |
| skip_cnt_o | output | SKIP_W | Count of skipped cycles, wrapping |

## Verification
The bench flips enable and permit right after the cycle-start sample. A design that tracked those levels live would cut the pulse short or start one in a cycle that should be skipped. It holds the current-limit flag high from the first clock and also raises it inside the blanking window. A wrong blanking count then shows up as a pulse of the wrong length by one or more clocks.

Fault flags are raised mid-pulse, and the bench checks the cycle after each one, so a design that cleared the fault on its own would fire too early. It also checks that the supply fault is already latched straight out of reset. A long run of skipped cycles carries the skip counter past its wrap point, which exposes a saturating or mis-sized counter.

// File: rtl/onoff_ctrl_pkg.sv
package onoff_ctrl_pkg;
  localparam int unsigned NUM_FLT = 2;
  localparam int unsigned FLT_SUPPLY = 0;
  localparam int unsigned FLT_THERM  = 1;
  // supply fault starts latched: the supply has not yet been seen charged
  localparam logic [NUM_FLT-1:0] FLT_RST = 2'b01;
endpackage

// File: rtl/fault_latch.sv
module fault_latch #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flt_o <= RST_VAL;
    else if (set_i) flt_o <= 1'b1;
    else if (clr_i) flt_o <= 1'b0;
  end
endmodule

// File: rtl/blank_timer.sv
module blank_timer #(
  parameter int unsigned BLANK_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/skip_counter.sv
module skip_counter #(
  parameter int unsigned SKIP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  output logic [SKIP_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/onoff_switch_ctrl.sv
module onoff_switch_ctrl
  import onoff_ctrl_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 3,
  parameter int unsigned SKIP_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_start_i,
  input  logic              dmax_i,
  input  logic              en_i,
  input  logic              ilim_i,
  input  logic              permit_i,
  input  logic              bp_low_i,
  input  logic              bp_ok_i,
  input  logic              hot_i,
  input  logic              cool_i,
  output logic              gate_o,
  output logic [SKIP_W-1:0] skip_cnt_o
);
  logic [NUM_FLT-1:0] flt_set, flt_clr, flt_q;
  logic fire, skip, blank_done, trip, gate_d, gate_q;

  assign flt_set[FLT_SUPPLY] = bp_low_i;
  assign flt_clr[FLT_SUPPLY] = bp_ok_i;
  assign flt_set[FLT_THERM]  = hot_i;
  assign flt_clr[FLT_THERM]  = cool_i;

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
    fault_latch #(.RST_VAL(FLT_RST[g])) u_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flt_set[g]),
      .clr_i  (flt_clr[g]),
      .flt_o  (flt_q[g])
    );
  end

  // single sample point per switching cycle
  assign fire = cyc_start_i & en_i & permit_i & dmax_i & ~|flt_q & ~|flt_set;
  assign skip = cyc_start_i & ~fire;

  // pulse end: window closed, unblanked current limit, or fresh fault
  assign trip = ~dmax_i | (ilim_i & blank_done) | |flt_set;

  always_comb begin
    gate_d = gate_q;
    if (fire)               gate_d = 1'b1;
    else if (cyc_start_i)   gate_d = 1'b0;
    else if (gate_q & trip) gate_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_d;
  end

  blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fire),
    .run_i  (gate_q),
    .done_o (blank_done)
  );

  skip_counter #(.SKIP_W(SKIP_W)) u_skip (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (skip),
    .cnt_o  (skip_cnt_o)
  );

  assign gate_o = gate_q;
endmodule

// File: rtl/onoff_switch_ctrl_chk.sv
module onoff_switch_ctrl_chk #(
  parameter int unsigned BLANK_CYC = 3,
  parameter int unsigned SKIP_W    = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc_start_i,
  input logic              dmax_i,
  input logic              en_i,
  input logic              ilim_i,
  input logic              permit_i,
  input logic              bp_low_i,
  input logic              hot_i,
  input logic              gate_o,
  input logic [SKIP_W-1:0] skip_cnt_o
);
  // clocks the gate has been on since the current cycle started
  logic [7:0] on_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          on_cnt_q <= '0;
    else if (cyc_start_i) on_cnt_q <= '0;
    else if (!gate_o)     on_cnt_q <= '0;
    else if (on_cnt_q != 8'hff) on_cnt_q <= on_cnt_q + 1'b1;
  end

  a_r1_rise_needs_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(cyc_start_i && en_i && permit_i));

  a_r5_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dmax_i |=> !gate_o);

  a_r3_limit_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && !cyc_start_i && ilim_i && on_cnt_q >= BLANK_CYC) |=> !gate_o);

  a_r4_blanked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && !cyc_start_i && dmax_i && !bp_low_i && !hot_i && on_cnt_q < BLANK_CYC)
      |=> gate_o);

  a_r6_supply_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_low_i |=> !gate_o);

  a_r7_therm_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot_i |=> !gate_o);

  a_r9_skip_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_i && !en_i) |=> (skip_cnt_o == $past(skip_cnt_o) + 1'b1));
endmodule

bind onoff_switch_ctrl onoff_switch_ctrl_chk #(
  .BLANK_CYC (BLANK_CYC),
  .SKIP_W    (SKIP_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cyc_start_i (cyc_start_i),
  .dmax_i      (dmax_i),
  .en_i        (en_i),
  .ilim_i      (ilim_i),
  .permit_i    (permit_i),
  .bp_low_i    (bp_low_i),
  .hot_i       (hot_i),
  .gate_o      (gate_o),
  .skip_cnt_o  (skip_cnt_o)
);

// File: tb/onoff_switch_ctrl_tb_top.sv
`timescale 1ns/1ps
module onoff_switch_ctrl_tb_top;
  localparam int BLANK  = 3;
  localparam int SKIPW  = 8;
  localparam int PER    = 16;
  localparam int WIN    = 10;
  localparam int NONE   = 99;

  logic clk = 0, rst_n = 0;
  logic cyc_start = 0, dmax = 0, en = 0, ilim = 0, permit = 0;
  logic bp_low = 0, bp_ok = 0, hot = 0, cool = 0;
  logic gate;
  logic [SKIPW-1:0] skip_cnt;

  always #10 clk = ~clk;

  onoff_switch_ctrl #(.BLANK_CYC(BLANK), .SKIP_W(SKIPW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cyc_start_i(cyc_start), .dmax_i(dmax),
    .en_i(en), .ilim_i(ilim), .permit_i(permit), .bp_low_i(bp_low),
    .bp_ok_i(bp_ok), .hot_i(hot), .cool_i(cool), .gate_o(gate),
    .skip_cnt_o(skip_cnt));

  int checks = 0, errors = 0;
  int exp_q[$];
  string tag_q[$];
  bit bp_f = 1, th_f = 0;
  int exp_skip = 0;
  bit finished = 0;

  function automatic int min2(int a, int b); return (a < b) ? a : b; endfunction
  function automatic int max2(int a, int b); return (a > b) ? a : b; endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: one switching cycle of PER clocks; pushes expected on-clocks
  task automatic sw_cycle(bit e, bit mid_e, bit pm, int ilim_at, int bp_at, int hot_at, string tag);
    bit fire;
    int n;
    fire = e && pm && !bp_f && !th_f && bp_at != 0 && hot_at != 0;
    n = fire ? min2(min2(WIN, max2(ilim_at, BLANK + 1)), min2(bp_at, hot_at)) : 0;
    exp_q.push_back(n);
    tag_q.push_back(tag);
    if (!fire) exp_skip++;
    if (bp_at < PER) bp_f = 1;
    if (hot_at < PER) th_f = 1;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      cyc_start = (i == 0);
      dmax      = (i < WIN);
      en        = (i == 0) ? e : mid_e;
      permit    = (i == 0) ? pm : !pm;
      ilim      = (i >= ilim_at);
      bp_low    = (i == bp_at);
      hot       = (i == hot_at);
    end
    @(negedge clk);
    cyc_start = 0; ilim = 0; bp_low = 0; hot = 0; dmax = 0;
  endtask

  task automatic pulse_ok(bit supply);
    @(negedge clk);
    if (supply) bp_ok = 1; else cool = 1;
    @(negedge clk);
    bp_ok = 0; cool = 0;
    if (supply) bp_f = 0; else th_f = 0;
  endtask

  // monitor: counts gate-on clocks per switching cycle, compares on next start
  initial begin
    int cnt = 0;
    bit open = 0;
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && cyc_start) begin
        if (open) begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, cnt, e);
        end
        open = 1;
        cnt = 0;
      end
      if (open && gate) cnt++;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 gate after reset", gate, 0);
    check("R10 skip after reset", skip_cnt, 0);

    sw_cycle(1, 1, 1, NONE, NONE, NONE, "R6 supply fault latched at reset");
    pulse_ok(1);
    sw_cycle(1, 1, 1, NONE, NONE, NONE, "R5 full window pulse");
    sw_cycle(1, 1, 1, 6, NONE, NONE, "R3 limit ends pulse");
    sw_cycle(1, 1, 1, 0, NONE, NONE, "R4 limit held from start");
    sw_cycle(1, 1, 1, 2, NONE, NONE, "R4 limit inside blanking");
    sw_cycle(1, 1, 1, BLANK + 1, NONE, NONE, "R4 limit at blanking end");
    sw_cycle(0, 1, 1, NONE, NONE, NONE, "R2 late enable rise ignored");
    sw_cycle(1, 0, 1, NONE, NONE, NONE, "R2 late enable fall ignored");
    sw_cycle(1, 1, 1, NONE, NONE, NONE, "R1 enabled cycle fires");
    sw_cycle(0, 0, 1, NONE, NONE, NONE, "R1 disabled cycle skipped");
    sw_cycle(1, 1, 0, NONE, NONE, NONE, "R8 permit low skips");
    sw_cycle(1, 1, 1, NONE, 5, NONE, "R6 supply trip mid pulse");
    sw_cycle(1, 1, 1, NONE, NONE, NONE, "R6 supply fault holds");
    pulse_ok(1);
    sw_cycle(1, 1, 1, NONE, NONE, NONE, "R6 supply recovered");
    sw_cycle(1, 1, 1, NONE, NONE, 7, "R7 thermal trip mid pulse");
    sw_cycle(1, 1, 1, NONE, NONE, NONE, "R7 thermal fault holds");
    pulse_ok(0);
    sw_cycle(1, 1, 1, NONE, NONE, NONE, "R7 thermal recovered");
    check("R9 skip count so far", skip_cnt, exp_skip % 256);

    base = exp_skip;
    for (int i = 0; i < 24; i++)
      sw_cycle(i % 3 != 0, 1, 1, 5, NONE, NONE, "R1 duty pattern");
    check("R9 skip ratio tracks enable duty", exp_skip - base, 8);
    check("R9 skip count after duty", skip_cnt, exp_skip % 256);

    for (int i = 0; i < 256; i++)
      sw_cycle(0, 0, 1, NONE, NONE, NONE, "R9 skip run");
    check("R9 skip wrap", skip_cnt, exp_skip % 256);

    sw_cycle(0, 0, 1, NONE, NONE, NONE, "flush");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule